// File: doc/BRIEF.md
# Real-Time Clock Interrupt Combiner

This block collects the four interrupt causes of a real-time clock (a seconds/minutes tick, a countdown-timer underflow, an alarm match and a periodic offset-correction event) and folds them onto one active-low, open-drain interrupt pin. The pin is modelled as an output-enable plus a drive value that is always 0. The counters, the alarm comparator and the register interface sit outside the block. They reach it as single-cycle strobes, enable levels and per-flag clear strobes. The block keeps three sticky status flags: minute/second, timer and alarm. Each one is readable on an output port.

Software picks one of two presentation styles for the two timer causes. In level style, the pin follows the sticky flag until software clears it. In pulse style, every timer event produces a pulse that lasts one period of a 128 Hz tick-enable input. The alarm always presents as a level. A correction event always presents as a pulse of one tick period, whichever style is chosen. All gated causes are OR-ed together. With every enable off, the pin is never driven.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After a clock edge with `rst_n` low, all three flags read 0 and `irq_oe` is 0.
- R2: `msf_o` becomes 1 one cycle after `sec_evt` with `en_sec`=1, or after `min_evt` with `en_min`=1. Neither strobe sets it while its own enable is 0. Once set, it stays 1 until `clr_msf`.
- R3: `tf_o` becomes 1 one cycle after `tmr_evt`, whatever the enables are. It returns to 0 only after a `clr_tf` strobe.
- R4: `af_o` becomes 1 one cycle after `alm_evt` and is cleared by `clr_af`. The alarm cause equals `af_o & en_alm` for both values of `pulse_mode`.
- R5: With `pulse_mode`=0, the minute/second cause equals `msf_o & (en_sec|en_min)` and the timer cause equals `tf_o & en_tmr`.
- R6: With `pulse_mode`=1, a qualifying minute/second event or a `tmr_evt` starts a pulse on the next cycle. The pulse lasts through the cycle of the next `tick_128` strobe. For an event that coincides with a tick, this is exactly one tick period.
- R7: `corr_evt` with `en_corr`=1 starts a correction pulse that behaves the same way, for both values of `pulse_mode`. No register strobe shortens it.
- R8: A clear strobe for the minute/second or timer flag also ends any pulse of that cause from the next cycle onward.
- R9: A set event and a clear strobe on the same flag in the same cycle leave the flag at 1.
- R10: `irq_oe` is the OR of the four gated causes.
- R11: When `en_sec`, `en_min`, `en_tmr`, `en_alm` and `en_corr` are all 0, `irq_oe` stays 0.
- R12: `irq_drv` is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_128 | input | 1 | One-cycle strobe at 128 Hz that times pulses |
| sec_evt | input | 1 | Seconds rollover strobe |
| min_evt | input | 1 | Minutes rollover strobe |
| tmr_evt | input | 1 | Countdown-timer underflow strobe |
| alm_evt | input | 1 | Alarm match strobe |
| corr_evt | input | 1 | Offset-correction strobe (1/64 Hz rate) |
| clr_msf | input | 1 | Clear minute/second flag |
| clr_tf | input | 1 | Clear timer flag |
| clr_af | input | 1 | Clear alarm flag |
| en_sec | input | 1 | Seconds interrupt enable |
| en_min | input | 1 | Minutes interrupt enable |
| en_tmr | input | 1 | Countdown-timer interrupt enable |
| en_alm | input | 1 | Alarm interrupt enable |
| en_corr | input | 1 | Correction interrupt enable |
| pulse_mode | input | 1 | 1: timer causes pulse; 0: timer causes follow flags |
| msf_o | output | 1 | Minute/second flag |
| tf_o | output | 1 | Timer flag |
| af_o | output | 1 | Alarm flag |
| irq_oe | output | 1 | Pin driven when 1 (interrupt asserted) |
| irq_drv | output | 1 | Value driven on the pin, constant 0 |

## Verification
A stuck or lost flag bit shows on its flag port one cycle after the strobe that should have moved it. When that cause is enabled in level style, it also shows on `irq_oe` in the same cycle. A pulse register that holds too long or drops too early is only visible while its cause is enabled and no other cause masks it. So a fault of this kind shows in the cycle after the expected tick, and only in configurations where the other causes are quiet. This is why the enable and style settings are swept exhaustively and each cause is also exercised alone.

// File: rtl/rtc_irq_pkg.sv
// Shared definitions for the RTC interrupt combiner.
package rtc_irq_pkg;
    localparam int unsigned NUM_SRC = 4;

    // Bit position of each cause in the merged source vectors.
    typedef enum logic [1:0] {
        SRC_MINSEC = 2'd0,
        SRC_TIMER  = 2'd1,
        SRC_ALARM  = 2'd2,
        SRC_CORR   = 2'd3
    } irq_src_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_status_flag.sv
// Sticky status flag. It is set by an event strobe and cleared by a register
// strobe. When both arrive in the same cycle, the set wins so no event is lost.
// Assumes: single-cycle strobes, synchronous active-low reset.
module irq_status_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    // Flag register: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    a_r3_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(clr_i));

endmodule

// File: rtl/irq_pulse_gen.sv
// Tick-timed pulse generator. A start strobe raises the pulse on the next
// cycle. The pulse falls after the next tick strobe, or after a cancel strobe
// when HAS_CANCEL is set. A start arriving with a tick or cancel retriggers.
// Assumes: the start strobe coincides with a tick when an exact one-period
// pulse is wanted.
module irq_pulse_gen #(
    parameter bit HAS_CANCEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic start_i,
    input  logic cancel_i,
    output logic pulse_o
);

    logic kill;

    // Select whether the cancel strobe can end a pulse.
    generate
        if (HAS_CANCEL) begin : g_cancel
            assign kill = cancel_i;
        end else begin : g_no_cancel
            assign kill = 1'b0;
        end
    endgenerate

    // Pulse state: start, then hold until tick or cancel.
    always_ff @(posedge clk) begin
        if (!rst_n)               pulse_o <= 1'b0;
        else if (start_i)         pulse_o <= 1'b1;
        else if (tick_i || kill)  pulse_o <= 1'b0;
    end

    a_r6_start_raises: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> pulse_o);
    a_r6_holds_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && !start_i && !tick_i && !cancel_i) |=> pulse_o);
    a_r6_tick_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !start_i) |=> !pulse_o);
    a_r8_cancel_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_CANCEL && cancel_i && !start_i) |=> !pulse_o);

endmodule

// File: rtl/irq_merge.sv
// Gating and wired-OR merge of the interrupt causes onto one open-drain pin.
// Assumes: each cause bit is already in its final pulse/level form.
module irq_merge
    import rtc_irq_pkg::*;
(
    input  src_vec_t src_act_i,
    input  src_vec_t src_en_i,
    output logic     irq_oe_o,
    output logic     irq_drv_o
);

    src_vec_t gated;

    // One AND gate per cause.
    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
            assign gated[i] = src_act_i[i] & src_en_i[i];
        end
    endgenerate

    // Drive the pin low while any gated cause is active; float otherwise.
    always_comb begin
        irq_oe_o  = (|gated) & (|src_en_i);
        irq_drv_o = 1'b0;
    end

endmodule

// File: rtl/rtc_irq_ctrl.sv
// RTC interrupt combiner top. It holds the minute/second, timer and alarm
// flags, forms a pulse or level view of each timer cause, produces the fixed
// correction pulse, and merges the causes onto an active-low open-drain pin.
// Assumes: all event and clear inputs are single-cycle strobes in clk; tick_128
// is a one-cycle strobe at 128 Hz; reset is synchronous, active low.
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_128,
    input  logic sec_evt,
    input  logic min_evt,
    input  logic tmr_evt,
    input  logic alm_evt,
    input  logic corr_evt,
    input  logic clr_msf,
    input  logic clr_tf,
    input  logic clr_af,
    input  logic en_sec,
    input  logic en_min,
    input  logic en_tmr,
    input  logic en_alm,
    input  logic en_corr,
    input  logic pulse_mode,
    output logic msf_o,
    output logic tf_o,
    output logic af_o,
    output logic irq_oe,
    output logic irq_drv
);

    logic     msf_set, corr_start;
    logic     msf_pulse, tf_pulse, corr_pulse;
    src_vec_t src_act, src_en;

    // Qualify the event strobes.
    always_comb begin
        msf_set    = (sec_evt & en_sec) | (min_evt & en_min);
        corr_start = corr_evt & en_corr;
    end

    irq_status_flag u_msf_flag (
        .clk(clk), .rst_n(rst_n), .set_i(msf_set), .clr_i(clr_msf), .flag_o(msf_o));
    irq_status_flag u_tf_flag (
        .clk(clk), .rst_n(rst_n), .set_i(tmr_evt), .clr_i(clr_tf), .flag_o(tf_o));
    irq_status_flag u_af_flag (
        .clk(clk), .rst_n(rst_n), .set_i(alm_evt), .clr_i(clr_af), .flag_o(af_o));

    irq_pulse_gen #(.HAS_CANCEL(1'b1)) u_msf_pulse (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_128), .start_i(msf_set),
        .cancel_i(clr_msf), .pulse_o(msf_pulse));
    irq_pulse_gen #(.HAS_CANCEL(1'b1)) u_tf_pulse (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_128), .start_i(tmr_evt),
        .cancel_i(clr_tf), .pulse_o(tf_pulse));
    irq_pulse_gen #(.HAS_CANCEL(1'b0)) u_corr_pulse (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_128), .start_i(corr_start),
        .cancel_i(1'b0), .pulse_o(corr_pulse));

    // Pick the pulse or level view of each cause and collect the enables.
    always_comb begin
        src_act             = '0;
        src_act[SRC_MINSEC] = pulse_mode ? msf_pulse : msf_o;
        src_act[SRC_TIMER]  = pulse_mode ? tf_pulse  : tf_o;
        src_act[SRC_ALARM]  = af_o;
        src_act[SRC_CORR]   = corr_pulse;
        src_en              = '0;
        src_en[SRC_MINSEC]  = en_sec | en_min;
        src_en[SRC_TIMER]   = en_tmr;
        src_en[SRC_ALARM]   = en_alm;
        src_en[SRC_CORR]    = en_corr;
    end

    irq_merge u_merge (
        .src_act_i(src_act), .src_en_i(src_en),
        .irq_oe_o(irq_oe), .irq_drv_o(irq_drv));

    a_r11_float_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_sec | en_min | en_tmr | en_alm | en_corr) |-> !irq_oe);
    a_r4_alarm_level: assert property (@(posedge clk) disable iff (!rst_n)
        (af_o && en_alm) |-> irq_oe);
    a_r10_corr_reaches_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_pulse && en_corr) |-> irq_oe);
    a_r5_level_timer: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && tf_o && en_tmr) |-> irq_oe);
    a_r2_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!msf_o && !(sec_evt && en_sec) && !(min_evt && en_min)) |=> !msf_o);

endmodule

// File: tb/rtc_irq_ctrl_tb_top.sv
// Self-checking bench: a cycle model built from the requirements, an
// exhaustive sweep of enable/style settings, and directed corner cases.
module rtc_irq_ctrl_tb_top;
    localparam int TICK_P = 8;
    localparam int WATCHDOG_CYC = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_128 = 1'b0;
    logic sec_evt = 1'b0, min_evt = 1'b0, tmr_evt = 1'b0, alm_evt = 1'b0, corr_evt = 1'b0;
    logic clr_msf = 1'b0, clr_tf = 1'b0, clr_af = 1'b0;
    logic en_sec = 1'b0, en_min = 1'b0, en_tmr = 1'b0, en_alm = 1'b0, en_corr = 1'b0;
    logic pulse_mode = 1'b0;
    logic msf_o, tf_o, af_o, irq_oe, irq_drv;

    int cyc = 0;
    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Model state
    bit m_msf, m_tf, m_af, m_pm, m_pt, m_pc;

    always #4 clk = ~clk;

    rtc_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .tick_128(tick_128),
        .sec_evt(sec_evt), .min_evt(min_evt), .tmr_evt(tmr_evt), .alm_evt(alm_evt),
        .corr_evt(corr_evt), .clr_msf(clr_msf), .clr_tf(clr_tf), .clr_af(clr_af),
        .en_sec(en_sec), .en_min(en_min), .en_tmr(en_tmr), .en_alm(en_alm),
        .en_corr(en_corr), .pulse_mode(pulse_mode),
        .msf_o(msf_o), .tf_o(tf_o), .af_o(af_o), .irq_oe(irq_oe), .irq_drv(irq_drv));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    function automatic bit exp_oe();
        bit ms_en;
        ms_en = en_sec | en_min;
        return (ms_en & (pulse_mode ? m_pm : m_msf)) | (en_tmr & (pulse_mode ? m_pt : m_tf))
             | (en_alm & m_af) | (en_corr & m_pc);
    endfunction

    // One clock: set tick, advance model from pre-edge inputs, sample after edge.
    task automatic step();
        bit s_ms, n_msf, n_tf, n_af, n_pm, n_pt, n_pc;
        tick_128 = (cyc % TICK_P) == 0;
        s_ms  = (sec_evt & en_sec) | (min_evt & en_min);
        n_msf = s_ms ? 1'b1 : (clr_msf ? 1'b0 : m_msf);
        n_tf  = tmr_evt ? 1'b1 : (clr_tf ? 1'b0 : m_tf);
        n_af  = alm_evt ? 1'b1 : (clr_af ? 1'b0 : m_af);
        n_pm  = s_ms ? 1'b1 : ((tick_128 | clr_msf) ? 1'b0 : m_pm);
        n_pt  = tmr_evt ? 1'b1 : ((tick_128 | clr_tf) ? 1'b0 : m_pt);
        n_pc  = (corr_evt & en_corr) ? 1'b1 : (tick_128 ? 1'b0 : m_pc);
        if (!rst_n) {n_msf, n_tf, n_af, n_pm, n_pt, n_pc} = '0;
        @(posedge clk);
        #1;
        cyc++;
        {m_msf, m_tf, m_af, m_pm, m_pt, m_pc} = {n_msf, n_tf, n_af, n_pm, n_pt, n_pc};
        {sec_evt, min_evt, tmr_evt, alm_evt, corr_evt, clr_msf, clr_tf, clr_af} = '0;
    endtask

    task automatic set_cfg(input logic [5:0] c);
        {pulse_mode, en_corr, en_alm, en_tmr, en_min, en_sec} = c;
    endtask

    task automatic align_tick();
        while ((cyc % TICK_P) != 0) step();
    endtask

    task automatic clear_all();
        clr_msf = 1'b1; clr_tf = 1'b1; clr_af = 1'b1;
        step();
        repeat (TICK_P) step();
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        int hi;
        lfsr = 16'hACE1;

        // R1: reset state
        rst_n = 1'b0;
        alm_evt = 1'b1; tmr_evt = 1'b1; en_alm = 1'b1; en_tmr = 1'b1;
        repeat (3) step();
        chk(msf_o == 1'b0, "R1 msf after reset", msf_o, 0);
        chk(tf_o == 1'b0, "R1 tf after reset", tf_o, 0);
        chk(af_o == 1'b0, "R1 af after reset", af_o, 0);
        chk(irq_oe == 1'b0, "R1 oe after reset", irq_oe, 0);
        rst_n = 1'b1;
        step();

        // Exhaustive sweep of enables and style with pseudo-random events.
        for (int c = 0; c < 64; c++) begin
            set_cfg(6'(c));
            for (int k = 0; k < 48; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                sec_evt  = lfsr[3:0] == 4'd1;
                min_evt  = lfsr[3:0] == 4'd2;
                tmr_evt  = lfsr[7:4] == 4'd3;
                alm_evt  = lfsr[7:4] == 4'd9;
                corr_evt = lfsr[11] && ((cyc % TICK_P) == 0);
                clr_msf  = lfsr[11:8] == 4'd5;
                clr_tf   = lfsr[15:12] == 4'd6;
                clr_af   = lfsr[15:12] == 4'd12;
                step();
                chk(msf_o == m_msf, "R2 msf flag", msf_o, m_msf);
                chk(tf_o == m_tf, "R3 tf flag", tf_o, m_tf);
                chk(af_o == m_af, "R4 af flag", af_o, m_af);
                if (c[4:0] == 5'd0)
                    chk(irq_oe == 1'b0, "R11 oe with all enables off", irq_oe, 0);
                else
                    chk(irq_oe == exp_oe(), "R10 merged oe", irq_oe, exp_oe());
                chk(irq_drv == 1'b0, "R12 drive value", irq_drv, 0);
            end
            clear_all();
        end

        // R5: level style, seconds cause holds the pin until cleared.
        set_cfg(6'b000001);
        sec_evt = 1'b1; step();
        repeat (3 * TICK_P) step();
        chk(irq_oe == 1'b1, "R5 level held", irq_oe, 1);
        clr_msf = 1'b1; step();
        chk(irq_oe == 1'b0, "R5 level released by clear", irq_oe, 0);

        // R2: minutes strobe ignored while minutes enable is off.
        set_cfg(6'b000001);
        min_evt = 1'b1; step();
        chk(msf_o == 1'b0, "R2 minutes ignored when disabled", msf_o, 0);
        chk(irq_oe == 1'b0, "R2 pin quiet", irq_oe, 0);

        // R6: pulse style, aligned seconds event gives exactly one tick period.
        set_cfg(6'b100001);
        align_tick();
        hi = 0;
        sec_evt = 1'b1;
        for (int k = 0; k < TICK_P + 4; k++) begin
            step();
            hi += int'(irq_oe);
        end
        chk(hi == TICK_P, "R6 pulse length", hi, TICK_P);
        chk(msf_o == 1'b1, "R6 flag stays set after pulse", msf_o, 1);
        clr_msf = 1'b1; step();

        // R7: correction pulse length, both styles.
        for (int pm = 0; pm < 2; pm++) begin
            set_cfg({pm[0], 5'b10000});
            align_tick();
            hi = 0;
            corr_evt = 1'b1;
            for (int k = 0; k < TICK_P + 4; k++) begin
                if (k == 2) clr_msf = 1'b1;
                step();
                hi += int'(irq_oe);
            end
            chk(hi == TICK_P, "R7 correction pulse length", hi, TICK_P);
        end

        // R8: clear cancels a timer pulse in progress.
        set_cfg(6'b100100);
        align_tick();
        tmr_evt = 1'b1; step();
        step();
        chk(irq_oe == 1'b1, "R8 pulse running", irq_oe, 1);
        clr_tf = 1'b1; step();
        chk(irq_oe == 1'b0, "R8 pulse cancelled", irq_oe, 0);
        chk(tf_o == 1'b0, "R8 flag cleared", tf_o, 0);

        // R9: simultaneous set and clear keep the flag.
        set_cfg(6'b000110);
        sec_evt = 1'b1; min_evt = 1'b1; clr_msf = 1'b1; step();
        chk(msf_o == 1'b1, "R9 msf set wins", msf_o, 1);
        tmr_evt = 1'b1; clr_tf = 1'b1; step();
        chk(tf_o == 1'b1, "R9 tf set wins", tf_o, 1);
        alm_evt = 1'b1; clr_af = 1'b1; step();
        chk(af_o == 1'b1, "R9 af set wins", af_o, 1);

        // R4: alarm stays a level in pulse style.
        set_cfg(6'b101000);
        repeat (2 * TICK_P) step();
        chk(irq_oe == 1'b1, "R4 alarm level in pulse style", irq_oe, 1);

        // R11: all enables off with every flag set.
        set_cfg(6'b100000);
        step();
        chk(irq_oe == 1'b0, "R11 floats with flags set", irq_oe, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule